// File: doc/BRIEF.md
# Light-Load Burst and Fault Restart Supervisor

This block is the mode supervisor of a fixed-frequency flyback controller. It works only on digitised comparator flags: four feedback levels, two soft-start levels, a supply overvoltage flag and an overtemperature flag. From these it decides when the controller leaves continuous switching for light-load burst operation and when it stops for a protective restart. Its outputs go to the analog side:
- a release for the soft-start clamp,
- a burst flag,
- an enable for the internal bias, which gates switching,
- a select for the reduced peak current limit,
- an auto-restart request for the supply sequencer.

Light load and overload do not change the mode at once. Either one first releases the soft-start clamp, which opens a blanking window. The new mode is taken only if the triggering feedback condition still holds when soft-start climbs past its upper threshold. If feedback returns to its normal band earlier, the clamp is re-engaged and nothing else happens.

Supply overvoltage and overtemperature reach the restart request through a spike-blanking counter. The counter length is `BLANK_CYC` clock cycles, which is 8 µs at 50 MHz with the default value. The restart request is sticky. Only the active-low power-down reset `rst_n` from the supply sequencer clears it.

Top module: `burst_fault_ctrl`

## Requirements
- R1: While and after reset, the outputs are: clamp release 0, burst flag 0, bias enable 1, low current-limit select 0, restart request 0.
- R2: In normal operation, a sampled `fb_above_ovl` or `fb_below_low` sets `ss_clamp_rel` at the next clock edge. If both flags are high, overload takes precedence.
- R3: If the triggering feedback flag drops before `ss_above_top` is seen, `ss_clamp_rel` returns to 0 at the next edge. Burst and restart stay 0.
- R4: With the low-load window open, `fb_below_low` and `ss_above_top` sampled together enter burst at the next edge. In burst, `burst_flag`=1, `ilim_low_sel`=1 and `bias_en`=0.
- R5: In burst, a sampled `fb_above_wake` sets `bias_en` at the next edge. A sampled low `fb_above_stop` clears it at the next edge. In between, `bias_en` holds its value.
- R6: In burst, a sampled `fb_above_ovl` returns the block to normal operation at the next edge. This gives `burst_flag`=0, `ilim_low_sel`=0 and `bias_en`=1.
- R7: With the overload window open, `fb_above_ovl` and `ss_above_top` sampled together raise `restart_req` at the next edge.
- R8: `vcc_ov` counts as a fault only while `ss_below_end` or `fb_above_ovl` is high. Outside those conditions it has no effect on `restart_req`.
- R9: A qualified fault must be sampled high on `BLANK_CYC` consecutive edges. `restart_req` rises at the last of those edges. A single low sample restarts the count from zero.
- R10: `hot_die` is a qualified fault on its own and passes through the same blanking count.
- R11: Once raised, `restart_req` stays 1 until reset, whatever the inputs do. While it is 1, `bias_en`, `burst_flag` and `ss_clamp_rel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-down reset from the supply sequencer |
| fb_below_low | input | 1 | Feedback below the low-load level |
| fb_above_stop | input | 1 | Feedback above the burst stop level |
| fb_above_wake | input | 1 | Feedback above the burst wake level |
| fb_above_ovl | input | 1 | Feedback above the overload level |
| ss_above_top | input | 1 | Soft-start above the window-closing threshold |
| ss_below_end | input | 1 | Soft-start below the end-of-soft-start level |
| vcc_ov | input | 1 | Supply overvoltage flag |
| hot_die | input | 1 | Junction overtemperature flag |
| ss_clamp_rel | output | 1 | Release of the soft-start clamp (blanking window open) |
| burst_flag | output | 1 | Burst mode active |
| bias_en | output | 1 | Internal bias enable; switching allowed |
| ilim_low_sel | output | 1 | Select the reduced peak current limit |
| restart_req | output | 1 | Sticky auto-restart request |

## Verification
Directed sequences use consistent feedback and soft-start levels, so that only physically possible flag combinations occur. They cover four paths:
- windows that close because feedback recovers, which separates clamp release from a real mode change;
- windows that close on the soft-start threshold, which separates burst entry from overload restart;
- a feedback sawtooth inside burst, which shows the wake and stop hysteresis against plain level-following;
- an overload jump out of burst.

Fault sequences hold overvoltage with soft-start high and feedback normal, then with soft-start low, which shows whether the qualification is applied. Interrupted runs one cycle short of the blanking count show whether the counter clears or only pauses.

A seeded random phase then mixes all levels, with periodic resets, against a cycle model in the bench.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [2:0] {
    M_RUN     = 3'd0,
    M_WIN_LOW = 3'd1,
    M_WIN_OVL = 3'd2,
    M_BURST   = 3'd3,
    M_RESTART = 3'd4
  } mode_t;
endpackage

// File: rtl/bfc_fault_blank.sv
module bfc_fault_blank #(
  parameter int BLANK_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ov,
  input  logic ss_below_end,
  input  logic fb_above_ovl,
  input  logic hot_die,
  output logic fault_hit
);
  localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
  localparam logic [CW-1:0] LIM = CW'(BLANK_CYC - 1);

  logic          qual;
  logic [CW-1:0] cnt;

  // overvoltage only counts during soft start or with feedback out of range
  assign qual      = (vcc_ov && (ss_below_end || fb_above_ovl)) || hot_die;
  assign fault_hit = qual && (cnt == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!qual)      cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + CW'(1);
  end

  // a hit always follows at least one earlier qualified sample
  p_hit_needs_history_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |-> $past(qual));

  // a low sample wipes the count, so no hit on the following cycle
  p_gap_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> !fault_hit);

  p_ov_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_ov && !ss_below_end && !fb_above_ovl && !hot_die) |-> !fault_hit);
endmodule

// File: rtl/bfc_burst_gate.sv
module bfc_burst_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic in_burst,
  input  logic fb_above_stop,
  input  logic fb_above_wake,
  output logic burst_on
);
  always_ff @(posedge clk) begin
    if (!rst_n)              burst_on <= 1'b0;
    else if (!in_burst)      burst_on <= 1'b0;
    else if (fb_above_wake)  burst_on <= 1'b1;
    else if (!fb_above_stop) burst_on <= 1'b0;
  end

  p_hyst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && fb_above_stop && !fb_above_wake) |=> (burst_on == $past(burst_on)));

  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && fb_above_wake) |=> burst_on);

  p_idle_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_burst |=> !burst_on);
endmodule

// File: rtl/bfc_mode_fsm.sv
module bfc_mode_fsm
  import bfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fb_below_low,
  input  logic  fb_above_ovl,
  input  logic  ss_above_top,
  input  logic  fault_hit,
  output mode_t mode
);
  mode_t nxt;

  always_comb begin
    nxt = mode;
    if (mode != M_RESTART && fault_hit) begin
      nxt = M_RESTART;
    end else begin
      unique case (mode)
        M_RUN: begin
          if (fb_above_ovl)      nxt = M_WIN_OVL;
          else if (fb_below_low) nxt = M_WIN_LOW;
        end
        M_WIN_LOW: begin
          if (!fb_below_low)     nxt = M_RUN;
          else if (ss_above_top) nxt = M_BURST;
        end
        M_WIN_OVL: begin
          if (!fb_above_ovl)     nxt = M_RUN;
          else if (ss_above_top) nxt = M_RESTART;
        end
        M_BURST: begin
          if (fb_above_ovl)      nxt = M_RUN;
        end
        M_RESTART: nxt = M_RESTART;
        default:   nxt = M_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= M_RUN;
    else        mode <= nxt;
  end

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RESTART) |=> (mode == M_RESTART));

  p_enter_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WIN_LOW && fb_below_low && ss_above_top && !fault_hit) |=> (mode == M_BURST));

  p_leave_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BURST && fb_above_ovl) |=> (mode != M_BURST));

  p_ovl_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WIN_OVL && fb_above_ovl && ss_above_top) |=> (mode == M_RESTART));
endmodule

// File: rtl/burst_fault_ctrl.sv
module burst_fault_ctrl
  import bfc_pkg::*;
#(
  parameter int BLANK_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_below_low,
  input  logic fb_above_stop,
  input  logic fb_above_wake,
  input  logic fb_above_ovl,
  input  logic ss_above_top,
  input  logic ss_below_end,
  input  logic vcc_ov,
  input  logic hot_die,
  output logic ss_clamp_rel,
  output logic burst_flag,
  output logic bias_en,
  output logic ilim_low_sel,
  output logic restart_req
);
  mode_t mode;
  logic  fault_hit;
  logic  burst_on;
  logic  in_burst;

  bfc_fault_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk          (clk),
    .rst_n        (rst_n),
    .vcc_ov       (vcc_ov),
    .ss_below_end (ss_below_end),
    .fb_above_ovl (fb_above_ovl),
    .hot_die      (hot_die),
    .fault_hit    (fault_hit)
  );

  bfc_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .fb_below_low (fb_below_low),
    .fb_above_ovl (fb_above_ovl),
    .ss_above_top (ss_above_top),
    .fault_hit    (fault_hit),
    .mode         (mode)
  );

  assign in_burst = (mode == M_BURST);

  bfc_burst_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_burst      (in_burst),
    .fb_above_stop (fb_above_stop),
    .fb_above_wake (fb_above_wake),
    .burst_on      (burst_on)
  );

  assign ss_clamp_rel = (mode == M_WIN_LOW) || (mode == M_WIN_OVL);
  assign burst_flag   = in_burst;
  assign ilim_low_sel = in_burst;
  assign restart_req  = (mode == M_RESTART);

  always_comb begin
    unique case (mode)
      M_BURST:   bias_en = burst_on;
      M_RESTART: bias_en = 1'b0;
      default:   bias_en = 1'b1;
    endcase
  end

  p_restart_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (!bias_en && !burst_flag && !ss_clamp_rel));

  p_clamp_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_clamp_rel && !burst_flag && !restart_req && (fb_above_ovl || fb_below_low) && !fault_hit)
      |=> ss_clamp_rel);
endmodule

// File: tb/sim_burst_fault_ctrl.sv
module sim_burst_fault_ctrl;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_below_low, fb_above_stop, fb_above_wake, fb_above_ovl;
  logic ss_above_top, ss_below_end, vcc_ov, hot_die;
  logic ss_clamp_rel, burst_flag, bias_en, ilim_low_sel, restart_req;

  int checks = 0;
  int errors = 0;
  int m_st = 0, m_bon = 0, m_cnt = 0;

  always #10 clk = ~clk;

  burst_fault_ctrl #(.BLANK_CYC(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fb_below_low(fb_below_low), .fb_above_stop(fb_above_stop),
    .fb_above_wake(fb_above_wake), .fb_above_ovl(fb_above_ovl),
    .ss_above_top(ss_above_top), .ss_below_end(ss_below_end),
    .vcc_ov(vcc_ov), .hot_die(hot_die),
    .ss_clamp_rel(ss_clamp_rel), .burst_flag(burst_flag), .bias_en(bias_en),
    .ilim_low_sel(ilim_low_sel), .restart_req(restart_req)
  );

  // feedback level 0..4: <low, low..stop, stop..wake, wake..ovl, >ovl
  // soft-start level 0..2: <end, clamped band, >top
  function automatic int next_mode(int st, int fbl, int ssl, bit hit);
    if (st == 4 || hit) return 4;
    case (st)
      0: return (fbl == 4) ? 2 : ((fbl == 0) ? 1 : 0);
      1: return (fbl != 0) ? 0 : ((ssl == 2) ? 3 : 1);
      2: return (fbl != 4) ? 0 : ((ssl == 2) ? 4 : 2);
      3: return (fbl == 4) ? 0 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_bias(int st, int bon);
    if (st <= 2) return 1'b1;
    if (st == 3) return bon[0];
    return 1'b0;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    chk(tag == "" ? "R2" : tag, "ss_clamp_rel", ss_clamp_rel, (m_st == 1 || m_st == 2));
    chk(tag == "" ? "R4" : tag, "burst_flag", burst_flag, (m_st == 3));
    chk(tag == "" ? "R5" : tag, "bias_en", bias_en, exp_bias(m_st, m_bon));
    chk(tag == "" ? "R6" : tag, "ilim_low_sel", ilim_low_sel, (m_st == 3));
    chk(tag == "" ? "R11" : tag, "restart_req", restart_req, (m_st == 4));
  endtask

  task automatic drive(int fbl, int ssl, bit ov, bit ot);
    fb_below_low  = (fbl == 0);
    fb_above_stop = (fbl >= 2);
    fb_above_wake = (fbl >= 3);
    fb_above_ovl  = (fbl == 4);
    ss_below_end  = (ssl == 0);
    ss_above_top  = (ssl == 2);
    vcc_ov        = ov;
    hot_die       = ot;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(int fbl, int ssl, bit ov, bit ot, string tag);
    bit qual, hit;
    int n_bon, n_cnt, n_st;
    drive(fbl, ssl, ov, ot);
    @(posedge clk);
    qual  = (ov && (ssl == 0 || fbl == 4)) || ot;
    hit   = qual && (m_cnt == N - 1);
    n_cnt = !qual ? 0 : ((m_cnt == N - 1) ? m_cnt : m_cnt + 1);
    n_bon = (m_st == 3) ? ((fbl >= 3) ? 1 : ((fbl < 2) ? 0 : m_bon)) : 0;
    n_st  = next_mode(m_st, fbl, ssl, hit);
    m_st = n_st; m_bon = n_bon; m_cnt = n_cnt;
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(2, 1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_st = 0; m_bon = 0; m_cnt = 0;
    cmp("R1");
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive(2, 1, 1'b0, 1'b0);
    do_reset();
    chk("R1", "bias_en after reset", bias_en, 1'b1);

    // R2 / R3: windows that collapse because feedback recovers
    step(4, 1, 0, 0, "R2");
    chk("R2", "clamp on overload", ss_clamp_rel, 1'b1);
    step(2, 1, 0, 0, "R3");
    chk("R3", "clamp back", ss_clamp_rel, 1'b0);
    step(0, 1, 0, 0, "R2");
    step(1, 1, 0, 0, "R3");
    chk("R3", "no burst", burst_flag, 1'b0);

    // R4: burst entry
    step(0, 1, 0, 0, "R2");
    step(0, 2, 0, 0, "R4");
    chk("R4", "burst entered", burst_flag, 1'b1);
    chk("R4", "bias off", bias_en, 1'b0);
    chk("R4", "low limit", ilim_low_sel, 1'b1);

    // R5: sawtooth hysteresis
    step(3, 1, 0, 0, "R5");
    chk("R5", "wake", bias_en, 1'b1);
    step(2, 1, 0, 0, "R5");
    chk("R5", "hold on", bias_en, 1'b1);
    step(1, 1, 0, 0, "R5");
    chk("R5", "stop", bias_en, 1'b0);
    step(2, 1, 0, 0, "R5");
    chk("R5", "hold off", bias_en, 1'b0);
    step(3, 1, 0, 0, "R5");

    // R6: leave burst on overload, then R7 overload restart
    step(4, 1, 0, 0, "R6");
    chk("R6", "burst left", burst_flag, 1'b0);
    chk("R6", "full limit", ilim_low_sel, 1'b0);
    step(4, 1, 0, 0, "R2");
    step(4, 2, 0, 0, "R7");
    chk("R7", "restart", restart_req, 1'b1);
    for (int i = 0; i < 5; i++) step(i % 5, i % 3, 0, 0, "R11");
    chk("R11", "sticky", restart_req, 1'b1);
    do_reset();
    chk("R1", "reset clears restart", restart_req, 1'b0);

    // R8: overvoltage with soft-start high and feedback normal is ignored
    for (int i = 0; i < N + 3; i++) step(2, 1, 1, 0, "R8");
    chk("R8", "ov masked", restart_req, 1'b0);
    for (int i = 0; i < N - 1; i++) step(2, 0, 1, 0, "R8");
    chk("R8", "one short", restart_req, 1'b0);
    step(2, 0, 1, 0, "R8");
    chk("R8", "ov qualified", restart_req, 1'b1);

    // R9: a gap restarts the blanking count
    do_reset();
    for (int i = 0; i < N - 1; i++) step(2, 0, 1, 0, "R9");
    step(2, 0, 0, 0, "R9");
    for (int i = 0; i < N - 1; i++) step(2, 0, 1, 0, "R9");
    chk("R9", "gap cleared count", restart_req, 1'b0);
    step(2, 0, 1, 0, "R9");
    chk("R9", "full count", restart_req, 1'b1);

    // R10: overtemperature
    do_reset();
    for (int i = 0; i < N - 1; i++) step(2, 1, 0, 1, "R10");
    chk("R10", "blanked", restart_req, 1'b0);
    step(2, 1, 0, 1, "R10");
    chk("R10", "hot restart", restart_req, 1'b1);

    // seeded random mix against the model
    void'($urandom(32'd20240611));
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      int fbl, ssl;
      bit ov, ot;
      if (c % 200 == 199) do_reset();
      fbl = int'($urandom_range(0, 4));
      if (m_st == 1 || m_st == 2) ssl = ($urandom_range(0, 3) == 0) ? 2 : 1;
      else ssl = ($urandom_range(0, 5) == 0) ? 0 : 1;
      ov = ($urandom_range(0, 2) == 0);
      ot = ($urandom_range(0, 29) == 0);
      step(fbl, ssl, ov, ot, "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule